// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec for Byte Words

This block protects 8-bit words with a 12-bit single-error-correcting Hamming code. It has two independent paths that share a clock. The encode path turns a data byte into a 12-bit codeword. The codeword carries four even-parity check bits.

The decode path takes a 12-bit word that may have been corrupted in storage. It recomputes the four parity groups to form a syndrome, inverts the bit the syndrome points at, and returns the recovered byte. It also returns the syndrome, an error flag and an uncorrectable flag. Both paths register their results and mark them with a valid strobe one clock after the input strobe.

Codeword positions are numbered 1 to 12, and position 1 is the most significant bit of the vector. Position p therefore sits at vector bit 12 − p.

Top module: `ham_sec_codec`

## Requirements
- R1: Check bits sit at positions 1, 2, 4 and 8 (vector bits 11, 10, 8, 4). The check bit at position 2^i makes even the number of ones among all positions whose number has bit i set.
- R2: Data bits fill the remaining positions in ascending order, MSB first. The placement is d7→3, d6→5, d5→6, d4→7, d3→9, d2→10, d1→11 and d0→12.
- R3: The encoder result and its valid strobe appear exactly one clock after an input with its valid strobe high. A cycle with the input strobe low gives the output strobe low on the next clock.
- R4: A decoded word whose parity groups all hold gives syndrome 0 and error flag 0, and returns the data bits unchanged.
- R5: When exactly one position p (1 to 12) is inverted, the syndrome equals p, the error flag is 1, the uncorrectable flag is 0, and the original byte is returned.
- R6: When the syndrome is 13, 14 or 15, the uncorrectable flag and the error flag are 1. The data is then taken from the received word with no bit inverted.
- R7: The decoder outputs and their valid strobe appear exactly one clock after an input with its valid strobe high. A cycle with the input strobe low gives the output strobe low on the next clock.
- R8: While reset is asserted (active low), every output is 0.
- R9: The encode and decode paths accept inputs in the same cycle without affecting each other.
- R10: The byte 10010100 encodes to 011100110100. The byte 00010100 encodes to 100100110100, and the byte 00010101 encodes to 100000100101 (all written from position 1 on the left).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| encValidIn | input | 1 | Encode request strobe |
| encDataIn | input | 8 | Byte to encode |
| encValidOut | output | 1 | Encoded word valid |
| encCodeOut | output | 12 | Encoded word, position 1 at bit 11 |
| decValidIn | input | 1 | Decode request strobe |
| decCodeIn | input | 12 | Received word, position 1 at bit 11 |
| decValidOut | output | 1 | Decode results valid |
| decDataOut | output | 8 | Recovered byte |
| decSyndrome | output | 4 | Syndrome, the failing position number |
| decErrFlag | output | 1 | Syndrome nonzero |
| decUncorrFlag | output | 1 | Syndrome beyond position 12 |

## Verification
An encode and a decode can be accepted in the same cycle. The sweep drives both strobes together on every step, so the two register sets update on the same edge. Each step feeds the encoder a byte and feeds the decoder that byte's reference codeword, either clean or with one of the twelve positions inverted. Both outputs are compared on the next cycle against values computed in the bench. Every byte is paired with every single-bit flip. A set of two-bit flips then reaches the syndromes 13 to 15, which confirms that the uncorrectable case returns the received data unchanged.

// File: rtl/ham_codec_pkg.sv
package ham_codec_pkg;

  // Number of check bits needed to correct one error in a dataW-bit word.
  function automatic int chkWidth(int dataW);
    for (int r = 1; r < 16; r++) begin
      if ((1 << r) >= dataW + r + 1) return r;
    end
    return 16;
  endfunction

  function automatic bit isPow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Bit index of a power-of-two position.
  function automatic int log2Pos(int p);
    for (int i = 0; i < 31; i++) begin
      if ((1 << i) == p) return i;
    end
    return 0;
  endfunction

  // Ordinal of a data position among the data positions, counted from 0.
  function automatic int dataOrd(int p);
    int n;
    n = 0;
    for (int q = 1; q < p; q++) begin
      if (!isPow2(q)) n++;
    end
    return n;
  endfunction

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } ctrlStrobes_t;

endpackage

// File: rtl/ham_codec_ctrl.sv
module ham_codec_ctrl (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       encValidIn,
  input  logic                       decValidIn,
  output ham_codec_pkg::ctrlStrobes_t strobes,
  output logic                       encValidOut,
  output logic                       decValidOut
);

  // Loads are gated by reset so the datapath registers stay cleared.
  assign strobes.encLoad = encValidIn & rstN;
  assign strobes.decLoad = decValidIn & rstN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encValidOut <= 1'b0;
      decValidOut <= 1'b0;
    end else begin
      encValidOut <= encValidIn;
      decValidOut <= decValidIn;
    end
  end

endmodule

// File: rtl/ham_codec_datapath.sv
module ham_codec_datapath #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ham_codec_pkg::ctrlStrobes_t strobes,
  input  logic [DATA_W-1:0]           encDataIn,
  input  logic [CODE_W-1:0]           decCodeIn,
  output logic [CODE_W-1:0]           encCodeOut,
  output logic [DATA_W-1:0]           decDataOut,
  output logic [CHK_W-1:0]            decSyndrome,
  output logic                        decErrFlag,
  output logic                        decUncorrFlag
);

  // Positions covered by check bit idx: those whose number has bit idx set.
  function automatic logic [CODE_W-1:0] coverMask(int idx);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (((p >> idx) & 1) == 1) m = m | (CODE_W'(1) << (CODE_W - p));
    end
    return m;
  endfunction

  logic [CODE_W-1:0] scattered;
  logic [CODE_W-1:0] encWord;
  logic [CHK_W-1:0]  encChk;
  logic [CHK_W-1:0]  synd;
  logic [CODE_W-1:0] flipMask;
  logic [CODE_W-1:0] fixedWord;
  logic [DATA_W-1:0] recovered;
  logic              synErr;
  logic              synBeyond;

  // Per-position wiring: data scatter, check insertion, flip and gather.
  for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
    if (ham_codec_pkg::isPow2(p)) begin : g_chk
      assign scattered[CODE_W-p] = 1'b0;
      assign encWord[CODE_W-p]   = encChk[ham_codec_pkg::log2Pos(p)];
    end else begin : g_dat
      assign scattered[CODE_W-p] = encDataIn[DATA_W-1-ham_codec_pkg::dataOrd(p)];
      assign encWord[CODE_W-p]   = scattered[CODE_W-p];
      assign recovered[DATA_W-1-ham_codec_pkg::dataOrd(p)] = fixedWord[CODE_W-p];
    end
    assign flipMask[CODE_W-p] = (synd == CHK_W'(p));
  end

  // Parity groups, shared shape for both paths.
  for (genvar i = 0; i < CHK_W; i++) begin : g_grp
    localparam logic [CODE_W-1:0] GRP = coverMask(i);
    assign encChk[i] = ^(scattered & GRP);
    assign synd[i]   = ^(decCodeIn & GRP);
  end

  assign synErr    = |synd;
  assign synBeyond = (synd > CHK_W'(CODE_W));
  // A syndrome beyond the last position matches no bit, so nothing flips.
  assign fixedWord = decCodeIn ^ flipMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encCodeOut <= '0;
    end else if (strobes.encLoad) begin
      encCodeOut <= encWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decDataOut    <= '0;
      decSyndrome   <= '0;
      decErrFlag    <= 1'b0;
      decUncorrFlag <= 1'b0;
    end else if (strobes.decLoad) begin
      decDataOut    <= recovered;
      decSyndrome   <= synd;
      decErrFlag    <= synErr;
      decUncorrFlag <= synBeyond;
    end
  end

endmodule

// File: rtl/ham_sec_codec.sv
module ham_sec_codec #(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = ham_codec_pkg::chkWidth(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encValidIn,
  input  logic [DATA_W-1:0] encDataIn,
  output logic              encValidOut,
  output logic [CODE_W-1:0] encCodeOut,
  input  logic              decValidIn,
  input  logic [CODE_W-1:0] decCodeIn,
  output logic              decValidOut,
  output logic [DATA_W-1:0] decDataOut,
  output logic [CHK_W-1:0]  decSyndrome,
  output logic              decErrFlag,
  output logic              decUncorrFlag
);

  ham_codec_pkg::ctrlStrobes_t strobes;

  ham_codec_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .encValidIn  (encValidIn),
    .decValidIn  (decValidIn),
    .strobes     (strobes),
    .encValidOut (encValidOut),
    .decValidOut (decValidOut)
  );

  ham_codec_datapath #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .CODE_W (CODE_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .encDataIn     (encDataIn),
    .decCodeIn     (decCodeIn),
    .encCodeOut    (encCodeOut),
    .decDataOut    (decDataOut),
    .decSyndrome   (decSyndrome),
    .decErrFlag    (decErrFlag),
    .decUncorrFlag (decUncorrFlag)
  );

endmodule

// File: rtl/ham_codec_chk.sv
module ham_codec_chk #(
  parameter  int DATA_W = 8,
  localparam int CHK_W  = ham_codec_pkg::chkWidth(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              encValidIn,
  input logic [DATA_W-1:0] encDataIn,
  input logic              encValidOut,
  input logic [CODE_W-1:0] encCodeOut,
  input logic              decValidIn,
  input logic [CODE_W-1:0] decCodeIn,
  input logic              decValidOut,
  input logic [DATA_W-1:0] decDataOut,
  input logic [CHK_W-1:0]  decSyndrome,
  input logic              decErrFlag,
  input logic              decUncorrFlag
);

  // Syndrome by walking positions: each set position number bit toggles its group.
  function automatic logic [CHK_W-1:0] refSyn(logic [CODE_W-1:0] w);
    logic [CHK_W-1:0] s;
    logic             b;
    s = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      b = 1'(w >> (CODE_W - p));
      for (int i = 0; i < CHK_W; i++) begin
        if (((p >> i) & 1) == 1) s = s ^ (CHK_W'(b) << i);
      end
    end
    return s;
  endfunction

  // Gather data bits from non-power-of-two positions, MSB first.
  function automatic logic [DATA_W-1:0] refGather(logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    logic              b;
    d = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        b = 1'(w >> (CODE_W - p));
        d = (d << 1) | DATA_W'(b);
      end
    end
    return d;
  endfunction

  // R3
  enc_valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValidIn |=> encValidOut);
  // R3
  enc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !encValidIn |=> !encValidOut);
  // R7
  dec_valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValidIn |=> decValidOut);
  // R7
  dec_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValidIn |=> !decValidOut);
  // R1
  enc_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValidOut |-> (refSyn(encCodeOut) == '0));
  // R2
  enc_place_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValidIn |=> (refGather(encCodeOut) == $past(encDataIn)));
  // R5
  dec_synd_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValidIn |=> (decSyndrome == $past(refSyn(decCodeIn))));
  // R4
  dec_errflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValidOut |-> (decErrFlag == (decSyndrome != '0)));
  // R6
  dec_uncorr_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValidOut |-> (decUncorrFlag == (decSyndrome > CHK_W'(CODE_W))));
  // R6
  dec_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValidIn && (refSyn(decCodeIn) > CHK_W'(CODE_W)))
      |=> (decDataOut == $past(refGather(decCodeIn))));

endmodule

bind ham_sec_codec ham_codec_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .encValidIn    (encValidIn),
  .encDataIn     (encDataIn),
  .encValidOut   (encValidOut),
  .encCodeOut    (encCodeOut),
  .decValidIn    (decValidIn),
  .decCodeIn     (decCodeIn),
  .decValidOut   (decValidOut),
  .decDataOut    (decDataOut),
  .decSyndrome   (decSyndrome),
  .decErrFlag    (decErrFlag),
  .decUncorrFlag (decUncorrFlag)
);

// File: tb/ham_sec_codec_tb_top.sv
`timescale 1ns/1ps
module ham_sec_codec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encValidIn = 1'b0;
  logic [7:0]  encDataIn = '0;
  logic        encValidOut;
  logic [11:0] encCodeOut;
  logic        decValidIn = 1'b0;
  logic [11:0] decCodeIn = '0;
  logic        decValidOut;
  logic [7:0]  decDataOut;
  logic [3:0]  decSyndrome;
  logic        decErrFlag;
  logic        decUncorrFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ham_sec_codec dut_i (
    .clk(clk), .rstN(rstN),
    .encValidIn(encValidIn), .encDataIn(encDataIn),
    .encValidOut(encValidOut), .encCodeOut(encCodeOut),
    .decValidIn(decValidIn), .decCodeIn(decCodeIn),
    .decValidOut(decValidOut), .decDataOut(decDataOut),
    .decSyndrome(decSyndrome), .decErrFlag(decErrFlag),
    .decUncorrFlag(decUncorrFlag)
  );

  // Position p (1..12) lives at vector bit 12-p.
  function automatic int posBit(int p);
    return 12 - p;
  endfunction

  function automatic bit isChk(int p);
    return (p == 1) || (p == 2) || (p == 4) || (p == 8);
  endfunction

  function automatic logic [11:0] refEncode(logic [7:0] d);
    logic [11:0] w;
    int k;
    w = '0;
    k = 7;
    for (int p = 1; p <= 12; p++) begin
      if (!isChk(p)) begin
        w[posBit(p)] = d[k];
        k--;
      end
    end
    for (int c = 1; c <= 8; c = c * 2) begin
      bit par;
      par = 0;
      for (int p = 1; p <= 12; p++) if ((p & c) != 0 && p != c) par ^= w[posBit(p)];
      w[posBit(c)] = par;
    end
    return w;
  endfunction

  function automatic logic [7:0] refExtract(logic [11:0] w);
    logic [7:0] d;
    int k;
    d = '0;
    k = 7;
    for (int p = 1; p <= 12; p++) begin
      if (!isChk(p)) begin
        d[k] = w[posBit(p)];
        k--;
      end
    end
    return d;
  endfunction

  function automatic logic [11:0] flipPos(logic [11:0] w, int p);
    if (p < 1 || p > 12) return w;
    return w ^ (12'b1 << posBit(p));
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive both paths at a falling edge; check at the next falling edge.
  task automatic step(bit ev, logic [7:0] ed, bit dv, logic [11:0] dc,
                      logic [11:0] expCode, logic [7:0] expData,
                      logic [3:0] expSyn, bit expUnc);
    encValidIn = ev; encDataIn = ed;
    decValidIn = dv; decCodeIn = dc;
    @(negedge clk);
    check(encValidOut == ev, "R3 enc valid", 32'(encValidOut), 32'(ev));
    check(decValidOut == dv, "R7 dec valid", 32'(decValidOut), 32'(dv));
    if (ev) check(encCodeOut == expCode, "R1 R2 R9 enc code", 32'(encCodeOut), 32'(expCode));
    if (dv) begin
      check(decSyndrome == expSyn, "R5 R9 dec syndrome", 32'(decSyndrome), 32'(expSyn));
      check(decDataOut == expData, "R4 R5 R6 dec data", 32'(decDataOut), 32'(expData));
      check(decErrFlag == (expSyn != 0), "R4 R5 dec err flag", 32'(decErrFlag), 32'(expSyn != 0));
      check(decUncorrFlag == expUnc, "R6 dec uncorr flag", 32'(decUncorrFlag), 32'(expUnc));
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state, even with strobes high.
    encValidIn = 1'b1; encDataIn = 8'hFF; decValidIn = 1'b1; decCodeIn = 12'hFFF;
    @(negedge clk);
    check(!encValidOut && !decValidOut, "R8 valids in reset", 32'({encValidOut, decValidOut}), 0);
    check(encCodeOut == 0, "R8 enc code in reset", 32'(encCodeOut), 0);
    check(decDataOut == 0 && decSyndrome == 0, "R8 dec outputs in reset",
          32'({decDataOut, decSyndrome}), 0);
    check(!decErrFlag && !decUncorrFlag, "R8 flags in reset",
          32'({decErrFlag, decUncorrFlag}), 0);
    encValidIn = 1'b0; decValidIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R10: fixed vectors, position 1 on the left.
    step(1, 8'b10010100, 0, '0, 12'b011100110100, '0, '0, 0);
    step(1, 8'b00010100, 0, '0, 12'b100100110100, '0, '0, 0);
    step(1, 8'b00010101, 0, '0, 12'b100000100101, '0, '0, 0);
    // R3 R7: idle cycle lowers both strobes.
    step(0, '0, 0, '0, '0, '0, '0, 0);

    // R9: both paths each cycle; R4 clean words, R5 every single flip.
    for (int d = 0; d < 256; d++) begin
      for (int e = 0; e <= 12; e++) begin
        logic [11:0] cw;
        cw = refEncode(8'(d));
        step(1, 8'(d), 1, flipPos(cw, e), cw, 8'(d), 4'(e), 0);
      end
    end
    step(0, '0, 0, '0, '0, '0, '0, 0);

    // R6: double flips; syndrome is the XOR of the two positions.
    for (int a = 1; a <= 12; a++) begin
      for (int b = a + 1; b <= 12; b++) begin
        logic [11:0] cw;
        logic [11:0] bad;
        logic [7:0]  expD;
        int s;
        cw = refEncode(8'hA5);
        bad = flipPos(flipPos(cw, a), b);
        s = a ^ b;
        expD = (s > 12) ? refExtract(bad) : refExtract(flipPos(bad, s));
        step(0, '0, 1, bad, '0, expD, 4'(s), s > 12);
      end
    end
    step(0, '0, 0, '0, '0, '0, '0, 0);
    finishRun();
  end

endmodule